// File: doc/BRIEF.md
# Byte-Wide Banked Memory Sequencer

This block sits between a 32-bit processor core and a memory system whose data path is one byte wide. The core issues a single request of one, two or four bytes. The sequencer breaks that request into consecutive byte cycles in ascending address order and returns the assembled little-endian word together with a one-clock completion pulse. Storage is reached over a shared byte address and byte write data, with one enable per bank.

Every byte address is decoded on its own. The top two address bits select one of four banks: a low RAM bank, a ROM bank, a peripheral bank and a high RAM bank. Because each byte is decoded separately, a wide access that runs past a bank edge continues into the next bank. Writes to the ROM bank are dropped.

The peripheral bank holds a small set of byte registers. These include a push-button input, the transmit, receive and control bytes of a serial engine, an output port, a note number for a tone generator and a second input port. The serial engine and the tone generator sit outside this block and see only these register ports.

Top module: `byte_bank_seq`

## Requirements
- R1: When the block is idle and cpu_rd or cpu_wr is high at a rising clock edge, the block latches cpu_addr, cpu_size and cpu_wdata. Strobes seen from that edge through the last byte cycle are ignored. If both strobes are high, the request is a write.
- R2: cpu_size 2'b00 makes one byte cycle, 2'b01 makes two, and 2'b10 or 2'b11 makes four. Byte cycles take one clock each, follow one another, and start in the clock right after the accepting edge.
- R3: cpu_done is high for exactly one clock, the clock after the last byte cycle. For a read, cpu_rdata is valid in that clock and holds until the next request is accepted. A new request may be accepted in the cycle where cpu_done is high.
- R4: Byte k of a request at address A uses byte address A+k modulo 2^16. It carries cpu_wdata[8k+7:8k] on writes and fills cpu_rdata[8k+7:8k] on reads. Read bytes beyond the request size are zero.
- R5: Bits [15:14] of each byte address select the bank: 0 gives low RAM (mem_en[0]), 1 gives ROM (mem_en[1]), 2 gives peripherals (mem_en[2]) and 3 gives high RAM (mem_en[3]). mem_addr is bits [11:0] of the byte address. mem_we is high in write byte cycles. Outside byte cycles, mem_en is zero and mem_we is low.
- R6: A write byte cycle that falls in the ROM bank drives mem_en to zero and mem_we low, so nothing is stored. The other bytes of the same request proceed normally.
- R7: Peripheral reads use offset bits [11:0] within bank 2. The mapping is: 0x000 gives btn_in, 0x001 gives the transmit register, 0x002 gives spi_rx_in, 0x003 gives the control register, 0x008 gives the output port register, 0x009 gives the note register and 0x00A gives aux_in. Every other offset reads 0.
- R8: A write to peripheral offset 0x001 loads spi_tx_data and raises spi_tx_start for the one clock after that byte cycle. A write to 0x003 loads spi_ctrl and a write to 0x008 loads port_out. Writes to offsets with no writable register change nothing. All registers reset to 0.
- R9: A write to offset 0x009 updates note_out only when the value is 0 or lies between 60 and 96 inclusive. Any other value leaves note_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Byte address of the request |
| cpu_size | input | 2 | Request size: 00 byte, 01 two bytes, 1x four bytes |
| cpu_rd | input | 1 | Read request strobe |
| cpu_wr | input | 1 | Write request strobe |
| cpu_wdata | input | 32 | Write data, least significant byte first in memory |
| cpu_rdata | output | 32 | Assembled read data |
| cpu_done | output | 1 | One-clock completion pulse |
| mem_en | output | 4 | One-hot bank enable for the current byte cycle |
| mem_we | output | 1 | Write enable for the current byte cycle |
| mem_addr | output | 12 | Byte offset within the bank |
| mem_wdata | output | 8 | Byte write data |
| ram_lo_rdata | input | 8 | Read byte from the low RAM bank |
| rom_rdata | input | 8 | Read byte from the ROM bank |
| ram_hi_rdata | input | 8 | Read byte from the high RAM bank |
| btn_in | input | 8 | Push-button input byte |
| spi_rx_in | input | 8 | Byte received by the serial engine |
| aux_in | input | 8 | Second input port |
| spi_tx_data | output | 8 | Transmit byte for the serial engine |
| spi_tx_start | output | 1 | One-clock pulse after a transmit byte is written |
| spi_ctrl | output | 8 | Serial engine control byte |
| port_out | output | 8 | Output port register |
| note_out | output | 8 | Tone note number, 0 means silent |

## Verification
The bench targets wide accesses that straddle a bank edge or wrap past address 0xFFFF. A design that decoded the bank once per request would write RAM bytes into ROM or the wrong bank, and the read-back would then differ. Strobes raised during a busy sequence and requests with both strobes high are also exercised: a design that re-latched mid-transfer would shift addresses or change data.

Note values just outside 60..96, writes to read-only and unmapped peripheral offsets, and narrow reads are checked as well. A slip in the range bounds would show up on note_out. A decoder that aliased unmapped offsets would return nonzero bytes, and a missing zero-fill would leave stale upper bytes.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   typedef enum logic [1:0] {
      BANK_RAM_LO = 2'd0,
      BANK_ROM    = 2'd1,
      BANK_IO     = 2'd2,
      BANK_RAM_HI = 2'd3
   } bank_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WALT = 2'b11
   } size_e;

   localparam int NUM_BANKS = 4;

endpackage

// File: rtl/bbs_bank_decode.sv
module bbs_bank_decode
   import bbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 12
) (
   input  logic [ADDR_W-1:0]    addr,
   output bank_e                bank,
   output logic [NUM_BANKS-1:0] sel,
   output logic [OFF_W-1:0]     offset
);

   localparam int GAP_W = ADDR_W - 2 - OFF_W;

   if (GAP_W < 0) begin : g_bad_widths
      $error("bbs_bank_decode: ADDR_W must cover OFF_W plus two bank bits");
   end

   assign bank   = bank_e'(addr[ADDR_W-1 -: 2]);
   assign offset = addr[OFF_W-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign sel[b] = (addr[ADDR_W-1 -: 2] == 2'(b));
   end

   if (GAP_W > 0) begin : g_gap
      // address bits between the offset and the bank field alias storage
      logic unused_gap;
      assign unused_gap = ^addr[ADDR_W-3:OFF_W];
   end

endmodule

// File: rtl/bbs_byte_seq.sv
module bbs_byte_seq
   import bbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic [ADDR_W-1:0] byte_addr,
   output logic              byte_wr,
   output logic [7:0]        byte_wdata,
   input  logic [7:0]        byte_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   localparam int NB    = DATA_W / 8;
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

   if ((DATA_W % 8) != 0 || DATA_W < 32) begin : g_bad_width
      $error("bbs_byte_seq: DATA_W must be a multiple of 8 and at least 32");
   end

   logic              busy_q;
   logic              wr_q;
   logic              done_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] acc_q;
   logic              accept;

   function automatic logic [IDX_W-1:0] last_index(input logic [1:0] sz);
      case (size_e'(sz))
         SZ_BYTE: return '0;
         SZ_HALF: return IDX_W'(1);
         default: return IDX_W'(NB - 1);
      endcase
   endfunction

   assign accept = !busy_q && (req_rd || req_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         wr_q    <= 1'b0;
         done_q  <= 1'b0;
         idx_q   <= '0;
         last_q  <= '0;
         base_q  <= '0;
         wdata_q <= '0;
         acc_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            wr_q    <= req_wr;
            idx_q   <= '0;
            last_q  <= last_index(req_size);
            base_q  <= req_addr;
            wdata_q <= req_wdata;
            acc_q   <= '0;
         end else if (busy_q) begin
            if (!wr_q) begin
               acc_q[8*idx_q +: 8] <= byte_rdata;
            end
            if (idx_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy       = busy_q;
   assign byte_addr  = base_q + ADDR_W'(idx_q);
   assign byte_wr    = busy_q && wr_q;
   assign byte_wdata = wdata_q[8*idx_q +: 8];
   assign rdata      = acc_q;
   assign done       = done_q;

endmodule

// File: rtl/bbs_periph_regs.sv
module bbs_periph_regs #(
   parameter int OFF_W   = 12,
   parameter int NOTE_LO = 60,
   parameter int NOTE_HI = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] offset,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic [7:0]       btn_in,
   input  logic [7:0]       spi_rx_in,
   input  logic [7:0]       aux_in,
   output logic [7:0]       spi_tx_data,
   output logic             spi_tx_start,
   output logic [7:0]       spi_ctrl,
   output logic [7:0]       port_out,
   output logic [7:0]       note_out
);

   localparam logic [OFF_W-1:0] OFS_BTN  = OFF_W'(12'h000);
   localparam logic [OFF_W-1:0] OFS_TX   = OFF_W'(12'h001);
   localparam logic [OFF_W-1:0] OFS_RX   = OFF_W'(12'h002);
   localparam logic [OFF_W-1:0] OFS_CTRL = OFF_W'(12'h003);
   localparam logic [OFF_W-1:0] OFS_PORT = OFF_W'(12'h008);
   localparam logic [OFF_W-1:0] OFS_NOTE = OFF_W'(12'h009);
   localparam logic [OFF_W-1:0] OFS_AUX  = OFF_W'(12'h00A);

   if (OFF_W < 4) begin : g_bad_off
      $error("bbs_periph_regs: OFF_W too small for the register map");
   end
   if (NOTE_LO < 1 || NOTE_HI > 255 || NOTE_LO > NOTE_HI) begin : g_bad_note
      $error("bbs_periph_regs: note range must lie within 1..255");
   end

   logic [7:0] tx_q;
   logic [7:0] ctrl_q;
   logic [7:0] port_q;
   logic [7:0] note_q;
   logic       start_q;

   function automatic logic note_legal(input logic [7:0] v);
      return (v == 8'd0) || ((v >= 8'(NOTE_LO)) && (v <= 8'(NOTE_HI)));
   endfunction

   always_comb begin
      case (offset)
         OFS_BTN:  rdata = btn_in;
         OFS_TX:   rdata = tx_q;
         OFS_RX:   rdata = spi_rx_in;
         OFS_CTRL: rdata = ctrl_q;
         OFS_PORT: rdata = port_q;
         OFS_NOTE: rdata = note_q;
         OFS_AUX:  rdata = aux_in;
         default:  rdata = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= 8'h00;
         ctrl_q  <= 8'h00;
         port_q  <= 8'h00;
         note_q  <= 8'h00;
         start_q <= 1'b0;
      end else begin
         start_q <= wr_en && (offset == OFS_TX);
         if (wr_en) begin
            case (offset)
               OFS_TX:   tx_q   <= wdata;
               OFS_CTRL: ctrl_q <= wdata;
               OFS_PORT: port_q <= wdata;
               OFS_NOTE: if (note_legal(wdata)) note_q <= wdata;
               default:  ;
            endcase
         end
      end
   end

   assign spi_tx_data  = tx_q;
   assign spi_tx_start = start_q;
   assign spi_ctrl     = ctrl_q;
   assign port_out     = port_q;
   assign note_out     = note_q;

endmodule

// File: rtl/byte_bank_seq.sv
module byte_bank_seq
   import bbs_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int OFF_W   = 12,
   parameter int DATA_W  = 32,
   parameter int NOTE_LO = 60,
   parameter int NOTE_HI = 96
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [1:0]           cpu_size,
   input  logic                 cpu_rd,
   input  logic                 cpu_wr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic [DATA_W-1:0]    cpu_rdata,
   output logic                 cpu_done,
   output logic [NUM_BANKS-1:0] mem_en,
   output logic                 mem_we,
   output logic [OFF_W-1:0]     mem_addr,
   output logic [7:0]           mem_wdata,
   input  logic [7:0]           ram_lo_rdata,
   input  logic [7:0]           rom_rdata,
   input  logic [7:0]           ram_hi_rdata,
   input  logic [7:0]           btn_in,
   input  logic [7:0]           spi_rx_in,
   input  logic [7:0]           aux_in,
   output logic [7:0]           spi_tx_data,
   output logic                 spi_tx_start,
   output logic [7:0]           spi_ctrl,
   output logic [7:0]           port_out,
   output logic [7:0]           note_out
);

   logic                 seq_busy;
   logic [ADDR_W-1:0]    seq_addr;
   logic                 seq_wr;
   logic [7:0]           seq_wdata;
   logic [7:0]           seq_rdata;
   bank_e                cur_bank;
   logic [NUM_BANKS-1:0] cur_sel;
   logic [OFF_W-1:0]     cur_off;
   logic [7:0]           io_rdata;
   logic                 rom_block;

   bbs_byte_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_rd     (cpu_rd),
      .req_wr     (cpu_wr),
      .req_addr   (cpu_addr),
      .req_size   (cpu_size),
      .req_wdata  (cpu_wdata),
      .busy       (seq_busy),
      .byte_addr  (seq_addr),
      .byte_wr    (seq_wr),
      .byte_wdata (seq_wdata),
      .byte_rdata (seq_rdata),
      .rdata      (cpu_rdata),
      .done       (cpu_done)
   );

   bbs_bank_decode #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_dec (
      .addr   (seq_addr),
      .bank   (cur_bank),
      .sel    (cur_sel),
      .offset (cur_off)
   );

   bbs_periph_regs #(
      .OFF_W   (OFF_W),
      .NOTE_LO (NOTE_LO),
      .NOTE_HI (NOTE_HI)
   ) u_io (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (seq_wr && cur_sel[BANK_IO]),
      .offset       (cur_off),
      .wdata        (seq_wdata),
      .rdata        (io_rdata),
      .btn_in       (btn_in),
      .spi_rx_in    (spi_rx_in),
      .aux_in       (aux_in),
      .spi_tx_data  (spi_tx_data),
      .spi_tx_start (spi_tx_start),
      .spi_ctrl     (spi_ctrl),
      .port_out     (port_out),
      .note_out     (note_out)
   );

   assign rom_block = seq_wr && cur_sel[BANK_ROM];

   always_comb begin
      case (cur_bank)
         BANK_RAM_LO: seq_rdata = ram_lo_rdata;
         BANK_ROM:    seq_rdata = rom_rdata;
         BANK_IO:     seq_rdata = io_rdata;
         default:     seq_rdata = ram_hi_rdata;
      endcase
   end

   assign mem_en    = (seq_busy && !rom_block) ? cur_sel : '0;
   assign mem_we    = seq_wr && !rom_block;
   assign mem_addr  = cur_off;
   assign mem_wdata = seq_wdata;

endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
   parameter int OFF_W   = 12,
   parameter int DATA_W  = 32,
   parameter int NOTE_LO = 60,
   parameter int NOTE_HI = 96
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             cpu_rd,
   input logic             cpu_wr,
   input logic [1:0]       cpu_size,
   input logic             cpu_done,
   input logic [3:0]       mem_en,
   input logic             mem_we,
   input logic [OFF_W-1:0] mem_addr,
   input logic [7:0]       note_out,
   input logic             spi_tx_start
);

   localparam int NB = DATA_W / 8;

   logic [7:0] cnt_q;
   logic [7:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
      end else if (!busy && (cpu_rd || cpu_wr)) begin
         cnt_q <= '0;
         len_q <= (cpu_size == 2'b00) ? 8'd1 : (cpu_size == 2'b01) ? 8'd2 : 8'(NB);
      end else if (busy) begin
         cnt_q <= cnt_q + 8'd1;
      end
   end

   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (cpu_rd || cpu_wr)) |=> busy);

   p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> (cnt_q == len_q));

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   p_done_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> (!busy && $past(busy)));

   p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   p_en_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_en));

   p_en_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_en == 4'b0000 && !mem_we));

   p_rom_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (!mem_en[1] && mem_en != 4'b0000));

   p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_tx_start |=> !spi_tx_start);

   p_note_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (note_out == 8'd0) || (note_out >= 8'(NOTE_LO) && note_out <= 8'(NOTE_HI)));

endmodule

bind byte_bank_seq bbs_checker #(
   .OFF_W   (OFF_W),
   .DATA_W  (DATA_W),
   .NOTE_LO (NOTE_LO),
   .NOTE_HI (NOTE_HI)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (seq_busy),
   .cpu_rd       (cpu_rd),
   .cpu_wr       (cpu_wr),
   .cpu_size     (cpu_size),
   .cpu_done     (cpu_done),
   .mem_en       (mem_en),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .note_out     (note_out),
   .spi_tx_start (spi_tx_start)
);

// File: tb/byte_bank_seq_tb.sv
module byte_bank_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_done;
   logic [3:0]  mem_en;
   logic        mem_we;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  ram_lo_rdata, rom_rdata, ram_hi_rdata;
   logic [7:0]  btn_in = '0, spi_rx_in = '0, aux_in = '0;
   logic [7:0]  spi_tx_data, spi_ctrl, port_out, note_out;
   logic        spi_tx_start;

   logic [7:0] ram_lo [64];
   logic [7:0] ram_hi [64];
   logic [7:0] rom_m  [64];
   logic [7:0] sh_lo  [64];
   logic [7:0] sh_hi  [64];
   logic [7:0] tx_sh = '0, ctrl_sh = '0, port_sh = '0, note_sh = '0;
   int n_checks = 0;
   int n_err = 0;
   int tx_pulses = 0;
   int exp_pulses = 0;

   always #4 clk = ~clk;

   byte_bank_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ram_lo_rdata(ram_lo_rdata), .rom_rdata(rom_rdata),
      .ram_hi_rdata(ram_hi_rdata), .btn_in(btn_in), .spi_rx_in(spi_rx_in),
      .aux_in(aux_in), .spi_tx_data(spi_tx_data), .spi_tx_start(spi_tx_start),
      .spi_ctrl(spi_ctrl), .port_out(port_out), .note_out(note_out)
   );

   assign ram_lo_rdata = ram_lo[mem_addr[5:0]];
   assign rom_rdata    = rom_m[mem_addr[5:0]];
   assign ram_hi_rdata = ram_hi[mem_addr[5:0]];

   always @(posedge clk) begin
      if (mem_we && mem_en[0]) ram_lo[mem_addr[5:0]] <= mem_wdata;
      if (mem_we && mem_en[3]) ram_hi[mem_addr[5:0]] <= mem_wdata;
      if (rst_n && spi_tx_start) tx_pulses = tx_pulses + 1;
   end

   function automatic logic [7:0] rom_val(input logic [5:0] i);
      return 8'(i) * 8'd37 + 8'd5;
   endfunction

   function automatic logic note_legal(input logic [7:0] v);
      return (v == 8'd0) || (v >= 8'd60 && v <= 8'd96);
   endfunction

   function automatic logic [7:0] ref_byte(input logic [15:0] a);
      case (a[15:14])
         2'd0: return sh_lo[a[5:0]];
         2'd1: return rom_val(a[5:0]);
         2'd3: return sh_hi[a[5:0]];
         default: begin
            case (a[11:0])
               12'h000: return btn_in;
               12'h001: return tx_sh;
               12'h002: return spi_rx_in;
               12'h003: return ctrl_sh;
               12'h008: return port_sh;
               12'h009: return note_sh;
               12'h00A: return aux_in;
               default: return 8'h00;
            endcase
         end
      endcase
   endfunction

   task automatic ref_write(input logic [15:0] a, input logic [7:0] d);
      case (a[15:14])
         2'd0: sh_lo[a[5:0]] = d;
         2'd3: sh_hi[a[5:0]] = d;
         2'd2: begin
            case (a[11:0])
               12'h001: begin tx_sh = d; exp_pulses++; end
               12'h003: ctrl_sh = d;
               12'h008: port_sh = d;
               12'h009: if (note_legal(d)) note_sh = d;
               default: ;
            endcase
         end
         default: ;
      endcase
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // starts and returns at a falling edge
   task automatic access(input bit is_wr, input bit both, input logic [15:0] a,
                         input logic [1:0] sz, input logic [31:0] wd, input bit poke);
      int n;
      logic [31:0] exp_rd;
      n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      exp_rd = '0;
      for (int k = 0; k < n; k++) exp_rd[8*k +: 8] = ref_byte(a + 16'(k));
      cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
      cpu_wr = is_wr; cpu_rd = !is_wr || both;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      if (poke) begin
         cpu_wr = 1'b1; cpu_addr = a ^ 16'h1234; cpu_wdata = ~wd;
      end
      for (int k = 0; k < n; k++) begin
         logic [15:0] ba;
         logic [3:0]  een;
         logic        rom_hit;
         ba = a + 16'(k);
         rom_hit = is_wr && (ba[15:14] == 2'd1);
         een = rom_hit ? 4'b0000 : (4'b0001 << ba[15:14]);
         chk(mem_addr == ba[11:0], "R5 mem_addr", 32'(mem_addr), 32'(ba[11:0]));
         chk(mem_en == een, "R5/R6 mem_en", 32'(mem_en), 32'(een));
         chk(mem_we == (is_wr && !rom_hit), "R6 mem_we", 32'(mem_we),
             32'(is_wr && !rom_hit));
         if (is_wr)
            chk(mem_wdata == wd[8*k +: 8], "R4 mem_wdata", 32'(mem_wdata),
                32'(wd[8*k +: 8]));
         chk(cpu_done == 1'b0, "R2 done early", 32'(cpu_done), 32'd0);
         @(negedge clk);
         if (k == 0) begin cpu_wr = 1'b0; cpu_addr = a; cpu_wdata = wd; end
      end
      chk(cpu_done == 1'b1, "R3 done", 32'(cpu_done), 32'd1);
      if (is_wr) begin
         for (int k = 0; k < n; k++) ref_write(a + 16'(k), wd[8*k +: 8]);
         chk(spi_tx_data == tx_sh, "R8 tx", 32'(spi_tx_data), 32'(tx_sh));
         chk(spi_ctrl == ctrl_sh, "R8 ctrl", 32'(spi_ctrl), 32'(ctrl_sh));
         chk(port_out == port_sh, "R8 port", 32'(port_out), 32'(port_sh));
         chk(note_out == note_sh, "R9 note", 32'(note_out), 32'(note_sh));
      end else begin
         chk(cpu_rdata == exp_rd, "R4/R7 rdata", cpu_rdata, exp_rd);
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL R3: watchdog expired actual=%0d expected=0", 1);
      finish_run();
   end

   initial begin
      logic [31:0] held;
      logic [7:0]  nv [6];
      void'($urandom(32'd8675309));
      for (int i = 0; i < 64; i++) begin
         rom_m[i] = rom_val(6'(i));
         ram_lo[i] = 8'(i); sh_lo[i] = 8'(i);
         ram_hi[i] = ~8'(i); sh_hi[i] = ~8'(i);
      end
      repeat (3) @(negedge clk);
      // reset state (R3, R5, R8)
      chk(cpu_done == 1'b0, "R3 reset done", 32'(cpu_done), 0);
      chk(mem_en == 4'b0 && !mem_we, "R5 reset en", 32'({mem_en, mem_we}), 0);
      chk(cpu_rdata == 32'h0, "R3 reset rdata", cpu_rdata, 0);
      chk({spi_tx_data, spi_ctrl, port_out, note_out} == 32'h0, "R8 reset regs",
          {spi_tx_data, spi_ctrl, port_out, note_out}, 0);
      chk(spi_tx_start == 1'b0, "R8 reset start", 32'(spi_tx_start), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 little-endian word, half and byte with zero fill
      access(1, 0, 16'h0010, 2'b10, 32'hA1B2C3D4, 0);
      access(0, 0, 16'h0010, 2'b10, 0, 0);
      access(0, 0, 16'h0012, 2'b01, 0, 0);
      chk(cpu_rdata == 32'h0000A1B2, "R4 half zero fill", cpu_rdata, 32'h0000A1B2);
      access(0, 0, 16'h0011, 2'b00, 0, 0);
      chk(cpu_rdata == 32'h000000C3, "R4 byte", cpu_rdata, 32'h000000C3);
      held = cpu_rdata;
      @(negedge clk);
      chk(cpu_done == 1'b0, "R3 done single", 32'(cpu_done), 0);
      @(negedge clk);
      chk(cpu_rdata == held, "R3 rdata held", cpu_rdata, held);

      // R5/R6 bank crossing into ROM, and 16-bit wrap
      access(1, 0, 16'h3FFE, 2'b11, 32'h11223344, 0);
      access(0, 0, 16'h3FFE, 2'b10, 0, 0);
      access(1, 0, 16'hFFFF, 2'b01, 32'h0000BEEF, 0);
      access(0, 0, 16'hFFFF, 2'b01, 0, 0);
      // R6 ROM write then read
      access(1, 0, 16'h4004, 2'b10, 32'hDEADBEEF, 0);
      access(0, 0, 16'h4004, 2'b10, 0, 0);

      // R1 both strobes mean write, strobes during busy ignored
      access(1, 1, 16'hC020, 2'b10, 32'h55AA6699, 0);
      access(0, 0, 16'hC020, 2'b10, 0, 1);
      access(1, 0, 16'h0020, 2'b00, 32'h0000007E, 1);
      access(0, 0, 16'h0020, 2'b10, 0, 0);

      // R7/R8 peripherals: read-only and unmapped offsets
      btn_in = 8'h5A; spi_rx_in = 8'h3C; aux_in = 8'hC3;
      access(1, 0, 16'h8000, 2'b00, 32'hFF, 0);
      access(1, 0, 16'h8004, 2'b10, 32'h01020304, 0);
      access(1, 0, 16'h800A, 2'b00, 32'h77, 0);
      access(0, 0, 16'h8004, 2'b10, 0, 0);
      chk(cpu_rdata == 32'h0, "R7 unmapped zero", cpu_rdata, 0);
      access(1, 0, 16'h8000, 2'b10, 32'h9A00E100, 0);
      access(0, 0, 16'h8000, 2'b10, 0, 0);
      access(0, 0, 16'h8008, 2'b10, 0, 0);
      @(negedge clk);
      @(negedge clk);
      chk(tx_pulses == exp_pulses, "R8 tx pulses", 32'(tx_pulses), 32'(exp_pulses));

      // R9 note bounds
      nv[0] = 8'd60; nv[1] = 8'd59; nv[2] = 8'd96; nv[3] = 8'd97;
      nv[4] = 8'd0;  nv[5] = 8'd200;
      foreach (nv[i]) access(1, 0, 16'h8009, 2'b00, 32'(nv[i]), 0);

      // constrained random mix
      for (int t = 0; t < 600; t++) begin
         logic [15:0] a;
         logic [31:0] d;
         int sel;
         bit w;
         sel = $urandom % 10;
         case (sel)
            0, 1: a = 16'h0000 | 16'($urandom % 64);
            2, 3: a = 16'hC000 | 16'($urandom % 64);
            4:    a = 16'h4000 | 16'($urandom % 64);
            5, 6: a = 16'h8000 | 16'($urandom % 18);
            7:    a = 16'h3FFC | 16'($urandom % 4);
            8:    a = 16'hBFFC | 16'($urandom % 4);
            default: a = 16'hFFFC | 16'($urandom % 4);
         endcase
         d = $urandom;
         if ($urandom % 3 == 0) d[7:0] = 8'(60 + $urandom % 37);
         btn_in = 8'($urandom); spi_rx_in = 8'($urandom); aux_in = 8'($urandom);
         w = ($urandom % 4) == 0;
         access(w, w && ($urandom % 8 == 0), a, 2'($urandom), d, ($urandom % 10) == 0);
      end
      @(negedge clk);
      @(negedge clk);
      chk(tx_pulses == exp_pulses, "R8 tx pulses final", 32'(tx_pulses), 32'(exp_pulses));
      for (int i = 0; i < 64; i++) begin
         chk(ram_lo[i] == sh_lo[i], "R5 ram_lo image", 32'(ram_lo[i]), 32'(sh_lo[i]));
         chk(ram_hi[i] == sh_hi[i], "R5 ram_hi image", 32'(ram_hi[i]), 32'(sh_hi[i]));
      end
      finish_run();
   end

endmodule